// File: doc/BRIEF.md
# Multicycle Load/Store Datapath

This block is the 32-bit data path of a small load/store processor. A whole instruction is spread over three to five clock cycles, so one adder/logic unit and one memory port can be used more than once per instruction. Each major unit writes its result into a holding register: the instruction word, the memory read data, the two operand registers and the ALU result. The value is then used in the following cycle. The program counter, the general register file and these holding registers all live inside the block.

The block makes no sequencing decisions of its own. An external controller drives a set of strobes each cycle: multiplexer selects, write enables for the program counter, instruction and register file, memory read/write, and a 3-bit ALU operation. The block returns the opcode, the function field and the ALU zero flag so that the controller can choose its next step. Memory sits outside the block and is reached through one combined address/data port that serves both instruction fetch and data access. The supported instructions are loads and stores of whole words, three-register arithmetic and logic, branch on equal, and an absolute jump.

Top module: `mcMulticycle`

## Requirements
- R1: Reset (rstN low) clears the program counter, the instruction register, the holding registers and all general registers. After release, memAddr reads 0 when iorD is 0, memWdata reads 0, and opcode and funct read 0.
- R2: When irWrite is 1, the instruction register takes memRdata at the clock edge. opcode shows instruction bits 31:26 and funct shows bits 5:0. Both hold their value while irWrite is 0.
- R3: The ALU operation codes are 000 AND, 001 OR, 010 add, 110 subtract and 111 signed set-less-than (result 1 or 0). The zero output is 1 exactly when the current ALU result is all zeros.
- R4: The first ALU operand is the PC when aluSrcA is 0 and register A when it is 1. The second operand is selected by aluSrcB: 00 register B, 01 the constant 4, 10 sign-extended bits 15:0, 11 the same value shifted left by 2. A fetch with add, PC and 4 moves the PC on by 4.
- R5: At every clock edge, A takes the register addressed by bits 25:21, B takes the register addressed by bits 20:16, and the ALU result register takes the ALU output. In the decode step, this puts the branch target PC+4+(offset<<2) into the ALU result register.
- R6: memAddr is the PC when iorD is 0 and the ALU result register when iorD is 1. memWdata is register B. memRd and memWr follow memRead and memWrite. A store therefore writes B to base + sign-extended offset.
- R7: The memory data register captures memRdata at every edge. With regWrite=1, memToReg=1 and regDst=0, it is written to the register addressed by bits 20:16 (load).
- R8: With regWrite=1, memToReg=0 and regDst=1, the ALU result register is written to the register addressed by bits 15:11 (arithmetic writeback).
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: The PC is loaded when pcWrite is 1, or when pcWriteCond is 1 and zero is 1; otherwise it holds. pcSource selects 00 the ALU output, 01 the ALU result register, 10 the jump target, 11 the ALU output.
- R11: The jump target is PC bits 31:28, then instruction bits 25:0, then two zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pcWrite | input | 1 | Unconditional PC load |
| pcWriteCond | input | 1 | PC load gated by the zero flag |
| iorD | input | 1 | Memory address select: 0 PC, 1 ALU result register |
| memRead | input | 1 | Memory read strobe |
| memWrite | input | 1 | Memory write strobe |
| irWrite | input | 1 | Instruction register load |
| memToReg | input | 1 | Register write data: 0 ALU result register, 1 memory data register |
| regDst | input | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| regWrite | input | 1 | Register file write enable |
| aluSrcA | input | 1 | First ALU operand: 0 PC, 1 register A |
| aluSrcB | input | 2 | Second ALU operand select |
| aluOp | input | 3 | ALU operation code |
| pcSource | input | 2 | PC next-value select |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Memory write data |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memRdata | input | 32 | Memory read data |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU result is zero |

## Verification
The assertions assume that the controller never asserts memRead and memWrite in the same cycle. They also assume that the PC-stability and PC-increment properties are judged only in cycles where iorD is 0, so that memAddr shows the PC. The bench acts as the controller and issues only the legal step sequences: fetch, decode, then the execute/memory/writeback steps of each instruction class. It never combines the two memory strobes, and it changes strobes just after a rising edge, so every property sees inputs that stay steady for a full cycle.

// File: rtl/mcPkg.sv
package mcPkg;
  localparam int XLEN = 32;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_IMMSH = 2'b11;

  localparam logic [1:0] PCSRC_ALU  = 2'b00;
  localparam logic [1:0] PCSRC_HOLD = 2'b01;
  localparam logic [1:0] PCSRC_JUMP = 2'b10;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       iorD;
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       memToReg;
    logic       regDst;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [2:0] aluOp;
    logic [1:0] pcSource;
  } strobeT;
endpackage

// File: rtl/mcRegFile.sv
module mcRegFile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RA  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [RA-1:0] rdAddrA,
  input  logic [RA-1:0] rdAddrB,
  input  logic          wrEn,
  input  logic [RA-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdDataA,
  output logic [DW-1:0] rdDataB
);
  logic [DW-1:0] regs [NREG];

  // Entry 0 is never written; its reads are forced to zero (R9)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/mcAlu.sv
module mcAlu
  import mcPkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic [2:0]    op,
  output logic [DW-1:0] result,
  output logic          isZero
);
  logic [DW-1:0] diff;
  logic          lessThan;

  assign diff     = opA - opB;
  assign lessThan = $signed(opA) < $signed(opB);

  always_comb begin
    unique case (op)
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = diff;
      ALU_SLT: result = {{(DW-1){1'b0}}, lessThan};
      default: result = '0;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/mcDatapath.sv
module mcDatapath
  import mcPkg::*;
#(
  parameter int DW   = XLEN,
  parameter int NREG = 32,
  localparam int RA  = $clog2(NREG),
  localparam int IMMW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        ctl,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [5:0]    opcode,
  output logic [5:0]    funct,
  output logic          zero
);
  logic [DW-1:0] pcQ, irQ, mdrQ, aQ, bQ, aluOutQ;
  logic [DW-1:0] rfA, rfB, rfWrData;
  logic [RA-1:0] rfWrAddr;
  logic [DW-1:0] srcA, srcB, aluRes, signExt, pcNext, jumpTarget;
  logic          pcEn;

  // Instruction fields
  logic [RA-1:0] fRs, fRt, fRd;
  assign fRs = irQ[25:21];
  assign fRt = irQ[20:16];
  assign fRd = irQ[15:11];

  assign signExt    = {{(DW-IMMW){irQ[IMMW-1]}}, irQ[IMMW-1:0]};
  assign jumpTarget = {pcQ[DW-1:DW-4], irQ[25:0], 2'b00};

  // Operand selection
  assign srcA = ctl.aluSrcA ? aQ : pcQ;
  always_comb begin
    unique case (ctl.aluSrcB)
      SRCB_REG:   srcB = bQ;
      SRCB_FOUR:  srcB = DW'(4);
      SRCB_IMM:   srcB = signExt;
      default:    srcB = {signExt[DW-3:0], 2'b00};
    endcase
  end

  mcAlu #(.DW(DW)) u_alu (
    .opA(srcA), .opB(srcB), .op(ctl.aluOp),
    .result(aluRes), .isZero(zero)
  );

  // Register file write path
  assign rfWrAddr = ctl.regDst ? fRd : fRt;
  assign rfWrData = ctl.memToReg ? mdrQ : aluOutQ;

  mcRegFile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rstN(rstN),
    .rdAddrA(fRs), .rdAddrB(fRt),
    .wrEn(ctl.regWrite), .wrAddr(rfWrAddr), .wrData(rfWrData),
    .rdDataA(rfA), .rdDataB(rfB)
  );

  // Next PC
  always_comb begin
    unique case (ctl.pcSource)
      PCSRC_HOLD: pcNext = aluOutQ;
      PCSRC_JUMP: pcNext = jumpTarget;
      default:    pcNext = aluRes;
    endcase
  end
  assign pcEn = ctl.pcWrite | (ctl.pcWriteCond & zero);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= '0;
      irQ     <= '0;
      mdrQ    <= '0;
      aQ      <= '0;
      bQ      <= '0;
      aluOutQ <= '0;
    end else begin
      if (pcEn)        pcQ <= pcNext;
      if (ctl.irWrite) irQ <= memRdata;
      mdrQ    <= memRdata;
      aQ      <= rfA;
      bQ      <= rfB;
      aluOutQ <= aluRes;
    end
  end

  assign memAddr  = ctl.iorD ? aluOutQ : pcQ;
  assign memWdata = bQ;
  assign opcode   = irQ[31:26];
  assign funct    = irQ[5:0];
endmodule

// File: rtl/mcMulticycle.sv
module mcMulticycle
  import mcPkg::*;
#(
  parameter int DW   = XLEN,
  parameter int NREG = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pcWrite,
  input  logic          pcWriteCond,
  input  logic          iorD,
  input  logic          memRead,
  input  logic          memWrite,
  input  logic          irWrite,
  input  logic          memToReg,
  input  logic          regDst,
  input  logic          regWrite,
  input  logic          aluSrcA,
  input  logic [1:0]    aluSrcB,
  input  logic [2:0]    aluOp,
  input  logic [1:0]    pcSource,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memRd,
  output logic          memWr,
  input  logic [DW-1:0] memRdata,
  output logic [5:0]    opcode,
  output logic [5:0]    funct,
  output logic          zero
);
  strobeT ctl;

  always_comb begin
    ctl.pcWrite     = pcWrite;
    ctl.pcWriteCond = pcWriteCond;
    ctl.iorD        = iorD;
    ctl.memRead     = memRead;
    ctl.memWrite    = memWrite;
    ctl.irWrite     = irWrite;
    ctl.memToReg    = memToReg;
    ctl.regDst      = regDst;
    ctl.regWrite    = regWrite;
    ctl.aluSrcA     = aluSrcA;
    ctl.aluSrcB     = aluSrcB;
    ctl.aluOp       = aluOp;
    ctl.pcSource    = pcSource;
  end

  mcDatapath #(.DW(DW), .NREG(NREG)) u_core (
    .clk(clk), .rstN(rstN), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  assign memRd = ctl.memRead;
  assign memWr = ctl.memWrite;
endmodule

// File: rtl/mcMulticycleChk.sv
module mcMulticycleChk
  import mcPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        pcWrite,
  input logic        pcWriteCond,
  input logic        iorD,
  input logic        memRead,
  input logic        memWrite,
  input logic        irWrite,
  input logic        aluSrcA,
  input logic [1:0]  aluSrcB,
  input logic [2:0]  aluOp,
  input logic [1:0]  pcSource,
  input logic [31:0] memAddr,
  input logic [31:0] memRdata,
  input logic [5:0]  opcode,
  input logic [5:0]  funct,
  input logic        zero
);
  // R10
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pcWrite && !(pcWriteCond && zero) && !iorD) |=> (iorD || $stable(memAddr)));

  // R4
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && pcSource == PCSRC_ALU && !aluSrcA && aluSrcB == SRCB_FOUR
     && aluOp == ALU_ADD && !iorD) |=> (iorD || memAddr == $past(memAddr) + 32'd4));

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irWrite |=> ($stable(opcode) && $stable(funct)));

  // R2
  ir_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    irWrite |=> (opcode == $past(memRdata[31:26]) && funct == $past(memRdata[5:0])));

  // R6
  one_mem_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRead && memWrite));
endmodule

bind mcMulticycle mcMulticycleChk u_chk (.*);

// File: tb/mcMulticycle_tb.sv
module mcMulticycle_tb;
  import mcPkg::*;

  logic clk = 1'b0;
  logic rstN;
  logic pcWrite, pcWriteCond, iorD, memRead, memWrite, irWrite;
  logic memToReg, regDst, regWrite, aluSrcA;
  logic [1:0] aluSrcB, pcSource;
  logic [2:0] aluOp;
  logic [31:0] memAddr, memWdata, memRdata;
  logic memRd, memWr, zero;
  logic [5:0] opcode, funct;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] memArr [256];
  logic [63:0] expQ [$];
  string       tagQ [$];

  always #4 clk = ~clk;

  mcMulticycle u_dut (.*);

  assign memRdata = memArr[memAddr[9:2]];
  always @(posedge clk) if (memWr) memArr[memAddr[9:2]] <= memWdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares every write request against the queue
  always @(negedge clk) begin
    if (rstN && memWr) begin
      if (expQ.size() == 0) begin
        chk("R6 unexpected store", memAddr, 32'hxxxx_xxxx);
      end else begin
        logic [63:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({t, " addr"}, memAddr, e[63:32]);
        chk({t, " data"}, memWdata, e[31:0]);
      end
    end
  end

  function automatic logic [31:0] rEnc(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iEnc(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic clr();
    {pcWrite, pcWriteCond, iorD, memRead, memWrite, irWrite} = '0;
    {memToReg, regDst, regWrite, aluSrcA} = '0;
    aluSrcB = 2'b00; aluOp = ALU_AND; pcSource = 2'b00;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fetchCyc(input logic [31:0] expPc, input string req);
    clr(); memRead = 1; irWrite = 1; aluSrcB = SRCB_FOUR; aluOp = ALU_ADD; pcWrite = 1;
    #1 chk(req, memAddr, expPc);
    tick();
  endtask

  task automatic decodeCyc(input logic [31:0] instr);
    clr(); aluSrcB = SRCB_IMMSH; aluOp = ALU_ADD;
    #1 chk("R2 opcode", {26'd0, opcode}, {26'd0, instr[31:26]});
    chk("R2 funct", {26'd0, funct}, {26'd0, instr[5:0]});
    tick();
  endtask

  task automatic rType(input logic [2:0] op3);
    clr(); aluSrcA = 1; aluOp = op3; tick();
    clr(); regDst = 1; regWrite = 1; tick();   // R8
  endtask

  task automatic addrCalc();
    clr(); aluSrcA = 1; aluSrcB = SRCB_IMM; aluOp = ALU_ADD; tick();
  endtask

  task automatic lwSteps();
    addrCalc();
    clr(); memRead = 1; iorD = 1; tick();
    clr(); memToReg = 1; regWrite = 1; tick();  // R7
  endtask

  task automatic swSteps(input logic [31:0] a, input logic [31:0] d, input string tag);
    addrCalc();
    expQ.push_back({a, d}); tagQ.push_back(tag);
    clr(); memWrite = 1; iorD = 1; tick();
  endtask

  task automatic beqSteps(input logic expZero, input string req);
    clr(); aluSrcA = 1; aluOp = ALU_SUB; pcWriteCond = 1; pcSource = PCSRC_HOLD;
    #1 chk(req, {31'd0, zero}, {31'd0, expZero});
    tick();
  endtask

  task automatic runInstr(input logic [31:0] pc, input string fetchReq);
    logic [31:0] ins;
    ins = memArr[pc[9:2]];
    fetchCyc(pc, fetchReq);
    decodeCyc(ins);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 256; i++) memArr[i] = 32'd0;
    memArr[64] = 32'd7;
    memArr[65] = 32'hFFFF_FFFD;
    memArr[66] = 32'h0000_0224;
    memArr[0]  = iEnc(6'h23, 0, 1, 16'h0100);
    memArr[1]  = iEnc(6'h23, 0, 2, 16'h0104);
    memArr[2]  = rEnc(1, 2, 3, 6'h20);
    memArr[3]  = rEnc(1, 2, 4, 6'h22);
    memArr[4]  = rEnc(1, 2, 5, 6'h24);
    memArr[5]  = rEnc(1, 2, 6, 6'h25);
    memArr[6]  = rEnc(2, 1, 7, 6'h2A);
    memArr[7]  = rEnc(1, 2, 8, 6'h2A);
    memArr[8]  = rEnc(1, 1, 0, 6'h20);
    for (int k = 0; k < 7; k++)
      memArr[9+k] = iEnc(6'h2B, 0, (k == 6) ? 0 : 3 + k, 16'(16'h0200 + 4*k));
    memArr[16] = iEnc(6'h04, 1, 2, 16'd5);
    memArr[17] = iEnc(6'h04, 3, 3, 16'd2);
    memArr[20] = {6'h02, 26'd30};
    memArr[30] = iEnc(6'h23, 0, 9, 16'h0108);
    memArr[31] = iEnc(6'h2B, 9, 1, 16'hFFFC);

    clr(); rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;
    chk("R1 pc", memAddr, 32'd0);
    chk("R1 regB", memWdata, 32'd0);
    chk("R1 opcode", {26'd0, opcode}, 32'd0);
    chk("R1 funct", {26'd0, funct}, 32'd0);
    @(posedge clk); #1;

    runInstr(0,  "R1 first fetch");  lwSteps();
    runInstr(4,  "R4 pc step");      lwSteps();
    runInstr(8,  "R4 pc step");      rType(ALU_ADD);
    runInstr(12, "R4 pc step");      rType(ALU_SUB);
    runInstr(16, "R4 pc step");      rType(ALU_AND);
    runInstr(20, "R4 pc step");      rType(ALU_OR);
    runInstr(24, "R4 pc step");      rType(ALU_SLT);
    runInstr(28, "R4 pc step");      rType(ALU_SLT);
    runInstr(32, "R4 pc step");      rType(ALU_ADD);
    runInstr(36, "R4 pc step");      swSteps(32'h200, 32'd4,         "R3 add");
    runInstr(40, "R4 pc step");      swSteps(32'h204, 32'd10,        "R3 sub");
    runInstr(44, "R4 pc step");      swSteps(32'h208, 32'd5,         "R3 and");
    runInstr(48, "R4 pc step");      swSteps(32'h20C, 32'hFFFF_FFFF, "R3 or");
    runInstr(52, "R4 pc step");      swSteps(32'h210, 32'd1,         "R3 slt true");
    runInstr(56, "R4 pc step");      swSteps(32'h214, 32'd0,         "R3 slt false");
    runInstr(60, "R4 pc step");      swSteps(32'h218, 32'd0,         "R9 r0 write ignored");
    runInstr(64, "R4 pc step");      beqSteps(1'b0, "R3 zero low");
    runInstr(68, "R10 branch not taken");  beqSteps(1'b1, "R3 zero high");
    runInstr(80, "R5 branch target taken");
    clr(); pcWrite = 1; pcSource = PCSRC_JUMP; tick();
    runInstr(120, "R11 jump target"); lwSteps();
    runInstr(124, "R4 pc step");      swSteps(32'h220, 32'd7, "R6 negative offset");
    fetchCyc(128, "R4 pc step");
    clr(); tick();

    chk("R6 all stores seen", 32'(expQ.size()), 32'd0);
    chk("R7 memory copy", memArr[136], 32'd7);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule